// File: doc/BRIEF.md
# Masking PRNG Reseed Scheduler

This block decides when the pseudo-random generator that feeds the masking logic of a cipher accelerator has to be reseeded. It counts the data blocks that the cipher completes. When the count reaches the interval picked by a one-hot rate select, it raises a reseed request. The request stays up until the entropy side acknowledges it, and the acknowledge clears the count.

Two other sources can also raise a request. A manual trigger raises one at any time. The arrival of a complete new key raises one only when the key-forces-reseed enable is set, and in that case the unit leaves idle although no data has been supplied. While a request is pending, the busy flag holds the cipher controller out of idle and new block completions are not counted. A rate select that is not one-hot is flagged, and it never produces a periodic request.

Top module: `reseed_sched`

## Requirements
- R1: After reset, `rsd_req_o` and `busy_o` are low and the block count is zero.
- R2: `rate_sel_i` is one-hot. Bit 0 selects an interval of 1 block, bit 1 an interval of 64 blocks and bit 2 an interval of 8192 blocks. On the clock edge where the accepted block completion brings the count to the selected interval, `rsd_req_o` rises.
- R3: A `rate_sel_i` value with zero bits set or with more than one bit set drives `rate_err_o` high in the same cycle. While it is applied, block completions are not counted and no periodic request is raised.
- R4: Once raised, `rsd_req_o` stays high until a cycle in which `rsd_ack_i` is high. On the edge that ends that cycle, it drops, unless a new trigger arrives in that same cycle.
- R5: A block completion that arrives while a request is pending is not counted.
- R6: An acknowledged reseed clears the block count to zero, and counting restarts from there.
- R7: A change of `rate_sel_i` clears the block count on the next edge. A block completion in the same cycle as the change is not counted.
- R8: With `key_force_en_i` high, a `key_full_i` pulse raises `rsd_req_o` and `busy_o` on the next edge.
- R9: With `key_force_en_i` low, a `key_full_i` pulse has no effect: `rsd_req_o` and `busy_o` stay low.
- R10: A `manual_rsd_i` pulse raises `rsd_req_o` on the next edge, whatever the rate select and the count.
- R11: `busy_o` is high exactly while a reseed request is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rate_sel_i | input | 3 | One-hot reseed rate select (bit 0: 1, bit 1: 64, bit 2: 8192 blocks) |
| key_force_en_i | input | 1 | A complete new key forces a reseed when high |
| blk_done_i | input | 1 | One cycle per completed data block |
| key_full_i | input | 1 | Pulse when a complete key has been written |
| manual_rsd_i | input | 1 | Manual reseed trigger pulse |
| rsd_ack_i | input | 1 | Reseed acknowledge from the entropy side |
| rsd_req_o | output | 1 | Reseed request, held until acknowledged |
| busy_o | output | 1 | Keeps the controller out of idle while a reseed is pending |
| rate_err_o | output | 1 | Rate select is not one-hot |

## Verification
The request, the busy flag and every clear of the count take effect on the first rising edge after the cycle that holds the trigger, acknowledge or rate change. The rate error flag is combinational and is valid in the cycle the select is applied. The bench drives all inputs on falling edges. It reads the outputs on the next falling edge, which is one rising edge after the stimulus, so each registered result is already settled there. Runs of consecutive block completions are checked one block short of the interval, where the request must still be low, and then on the final block, where it must be high.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

  // true when exactly one rate bit is set
  function automatic logic rate_legal(input logic [2:0] sel);
    return $countones(sel) == 1;
  endfunction

  // interval in blocks for a legal one-hot select; 0 when illegal
  function automatic int unsigned rate_interval(input logic [2:0] sel,
                                                input int unsigned fast_n,
                                                input int unsigned mid_n,
                                                input int unsigned slow_n);
    int unsigned lim;
    lim = 0;
    if (rate_legal(sel)) begin
      if (sel[0]) lim = fast_n;
      if (sel[1]) lim = mid_n;
      if (sel[2]) lim = slow_n;
    end
    return lim;
  endfunction

endpackage

// File: rtl/rsd_rate_dec.sv
module rsd_rate_dec #(
  parameter int unsigned FAST_N = 1,
  parameter int unsigned MID_N  = 64,
  parameter int unsigned SLOW_N = 8192,
  parameter int unsigned CNT_W  = 14
) (
  input  logic [2:0]       sel_i,
  output logic [CNT_W-1:0] lim_o,
  output logic             err_o
);
  import rsd_pkg::*;

  always_comb begin
    err_o = !rate_legal(sel_i);
    lim_o = CNT_W'(rate_interval(sel_i, FAST_N, MID_N, SLOW_N));
  end
endmodule

// File: rtl/rsd_blk_cnt.sv
module rsd_blk_cnt #(
  parameter int unsigned CNT_W = 14
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] lim_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             hit_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nx;

  assign cnt_nx = cnt_q + CNT_W'(1);
  assign hit_o  = inc_i && (cnt_nx == lim_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_nx;
  end
endmodule

// File: rtl/rsd_req_ctl.sv
module rsd_req_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  output logic req_o
);
  logic req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= 1'b0;
    else         req_q <= set_i | (req_q & ~ack_i);
  end

  assign req_o = req_q;
endmodule

// File: rtl/reseed_sched.sv
module reseed_sched #(
  parameter int unsigned FAST_N = 1,
  parameter int unsigned MID_N  = 64,
  parameter int unsigned SLOW_N = 8192,
  localparam int unsigned CNT_W = $clog2(SLOW_N + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] rate_sel_i,
  input  logic       key_force_en_i,
  input  logic       blk_done_i,
  input  logic       key_full_i,
  input  logic       manual_rsd_i,
  input  logic       rsd_ack_i,
  output logic       rsd_req_o,
  output logic       busy_o,
  output logic       rate_err_o
);
  // named internal events
  logic [2:0]       rate_q;
  logic             rate_chg;
  logic [CNT_W-1:0] lim;
  logic [CNT_W-1:0] cnt;
  logic             hit;
  logic             blk_take;
  logic             key_trig;
  logic             rsd_done;
  logic             cnt_clr;
  logic             req_set;
  logic             req;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rate_q <= 3'b001;
    else         rate_q <= rate_sel_i;
  end

  assign rate_chg = rate_sel_i != rate_q;

  rsd_rate_dec #(
    .FAST_N(FAST_N), .MID_N(MID_N), .SLOW_N(SLOW_N), .CNT_W(CNT_W)
  ) u_dec (
    .sel_i(rate_sel_i),
    .lim_o(lim),
    .err_o(rate_err_o)
  );

  assign blk_take = blk_done_i & ~req & ~rate_err_o & ~rate_chg;
  assign rsd_done = req & rsd_ack_i;
  assign cnt_clr  = rate_chg | rsd_done;
  assign key_trig = key_full_i & key_force_en_i;

  rsd_blk_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .inc_i (blk_take),
    .lim_i (lim),
    .cnt_o (cnt),
    .hit_o (hit)
  );

  assign req_set = hit | manual_rsd_i | key_trig;

  rsd_req_ctl u_req (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (req_set),
    .ack_i (rsd_ack_i),
    .req_o (req)
  );

  assign rsd_req_o = req;
  assign busy_o    = req;
endmodule

// File: rtl/rsd_sched_chk.sv
module rsd_sched_chk #(
  parameter int unsigned CNT_W = 14
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             rsd_req_o,
  input logic             busy_o,
  input logic             rsd_ack_i,
  input logic             manual_rsd_i,
  input logic             key_full_i,
  input logic             key_force_en_i,
  input logic             blk_done_i,
  input logic             rate_err_o,
  input logic             rate_chg,
  input logic             hit,
  input logic             blk_take,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] lim
);
  // R4
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsd_req_o && !rsd_ack_i |=> rsd_req_o);

  // R5
  pend_nocount_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsd_req_o && !rsd_ack_i && !rate_chg |=> $stable(cnt));

  // R6
  ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsd_req_o && rsd_ack_i |=> cnt == '0);

  // R7
  chg_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_chg |=> cnt == '0);

  // R3
  bad_rate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rate_err_o |-> !hit && !blk_take);

  // R8
  key_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_full_i && key_force_en_i |=> rsd_req_o && busy_o);

  // R9
  key_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsd_req_o && key_full_i && !key_force_en_i && !manual_rsd_i && !hit
    |=> !rsd_req_o);

  // R10
  manual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    manual_rsd_i |=> rsd_req_o);

  // R2
  hit_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> rsd_req_o);

  // R11
  busy_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == rsd_req_o);

  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rate_err_o && !rate_chg |-> cnt <= lim);
endmodule

bind reseed_sched rsd_sched_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .rsd_req_o     (rsd_req_o),
  .busy_o        (busy_o),
  .rsd_ack_i     (rsd_ack_i),
  .manual_rsd_i  (manual_rsd_i),
  .key_full_i    (key_full_i),
  .key_force_en_i(key_force_en_i),
  .blk_done_i    (blk_done_i),
  .rate_err_o    (rate_err_o),
  .rate_chg      (rate_chg),
  .hit           (hit),
  .blk_take      (blk_take),
  .cnt           (cnt),
  .lim           (lim)
);

// File: tb/test_reseed_sched.sv
`timescale 1ns/1ps
module test_reseed_sched;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] rate = 3'b001;
  logic       kfe = 1'b0, blk = 1'b0, kful = 1'b0, man = 1'b0, ack = 1'b0;
  logic       req, busy, rerr;
  int         n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  reseed_sched i_reseed_sched (
    .clk_i(clk), .rst_ni(rst_n), .rate_sel_i(rate), .key_force_en_i(kfe),
    .blk_done_i(blk), .key_full_i(kful), .manual_rsd_i(man), .rsd_ack_i(ack),
    .rsd_req_o(req), .busy_o(busy), .rate_err_o(rerr)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // n back-to-back block completions, then back on a falling edge
  task automatic blocks(input int n);
    @(negedge clk); blk = 1'b1;
    repeat (n) @(negedge clk);
    blk = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic set_rate(input logic [2:0] r);
    @(negedge clk); rate = r;
    @(negedge clk);
  endtask

  task automatic t_reset();
    idle(2);
    check("R1 req after reset", req, 1'b0);
    check("R1 busy after reset", busy, 1'b0);
    blocks(1); // count 0 with interval 1 -> request at once
    check("R1 count starts at zero", req, 1'b1);
    do_ack();
    check("R4 req drops after ack", req, 1'b0);
    check("R11 busy follows req", busy, 1'b0);
  endtask

  task automatic t_rate64();
    set_rate(3'b010);
    blocks(63);
    check("R2 no req at 63 of 64", req, 1'b0);
    blocks(1);
    check("R2 req at 64th block", req, 1'b1);
    check("R11 busy with req", busy, 1'b1);
    idle(3);
    check("R4 req held without ack", req, 1'b1);
    blocks(5); // R5: ignored while pending
    do_ack();
    check("R6 req cleared by ack", req, 1'b0);
    blocks(63);
    check("R5 R6 restart from zero (63)", req, 1'b0);
    blocks(1);
    check("R6 req at 64 after restart", req, 1'b1);
    do_ack();
  endtask

  task automatic t_rate8k();
    set_rate(3'b100);
    blocks(8191);
    check("R2 no req at 8191 of 8192", req, 1'b0);
    blocks(1);
    check("R2 req at 8192nd block", req, 1'b1);
    do_ack();
  endtask

  task automatic t_illegal();
    @(negedge clk); rate = 3'b011;
    #1 check("R3 err for two bits", rerr, 1'b1);
    @(negedge clk); rate = 3'b000;
    #1 check("R3 err for no bits", rerr, 1'b1);
    blocks(70);
    check("R3 no periodic req", req, 1'b0);
    @(negedge clk); rate = 3'b001;
    #1 check("R3 err clear for legal", rerr, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_rate_change();
    set_rate(3'b010);
    blocks(10);
    set_rate(3'b001);
    set_rate(3'b010);
    blocks(63);
    check("R7 change cleared count", req, 1'b0);
    blocks(1);
    check("R7 req at 64 after change", req, 1'b1);
    do_ack();
    // block in the same cycle as a change is not counted
    @(negedge clk); rate = 3'b001; blk = 1'b1;
    @(negedge clk); blk = 1'b0;
    check("R7 block at change ignored", req, 1'b0);
    blocks(1);
    check("R7 next block counted", req, 1'b1);
    do_ack();
  endtask

  task automatic t_key();
    set_rate(3'b010);
    kfe = 1'b0;
    @(negedge clk); kful = 1'b1;
    @(negedge clk); kful = 1'b0;
    check("R9 key no force req", req, 1'b0);
    check("R9 key no force busy", busy, 1'b0);
    kfe = 1'b1;
    @(negedge clk); kful = 1'b1;
    @(negedge clk); kful = 1'b0;
    check("R8 key force req", req, 1'b1);
    check("R8 key force busy", busy, 1'b1);
    do_ack();
    kfe = 1'b0;
  endtask

  task automatic t_manual();
    blocks(5);
    @(negedge clk); man = 1'b1;
    @(negedge clk); man = 1'b0;
    check("R10 manual req", req, 1'b1);
    // ack with a new trigger in the same cycle keeps the request
    @(negedge clk); ack = 1'b1; man = 1'b1;
    @(negedge clk); ack = 1'b0; man = 1'b0;
    check("R4 new trigger beats ack", req, 1'b1);
    do_ack();
    check("R4 dropped after plain ack", req, 1'b0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    t_reset();
    t_rate64();
    t_rate8k();
    t_illegal();
    t_rate_change();
    t_key();
    t_manual();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1500000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule